// File: doc/BRIEF.md
# CAN Status and Interrupt Register Logic

This block sits on the register side of a CAN controller. It takes live status from the protocol engine: bus idle, transmitting or receiving, the fault-confinement code and six error event bits. It presents them in a 32-bit status word that the CPU reads through a simple register port. It keeps two sticky summary flags, one for bus-off and one for errors. The CPU clears each flag by writing 1 to its bit. The block also masks the completion flags of message buffers 32 to 63 with a per-buffer enable register. It drives a single registered interrupt request line.

The reported confinement state is held in a small state machine with three states: CONF_ACTIVE, CONF_PASSIVE and CONF_BUSOFF. On each clock, the next state follows the engine's code. Code 00 moves it to CONF_ACTIVE, code 01 to CONF_PASSIVE, and code 1X to CONF_BUSOFF. The listen-only bit forces the transition to CONF_PASSIVE from every state. A soft reset moves the machine to CONF_ACTIVE, or to CONF_PASSIVE while listen-only is set. The transition into CONF_BUSOFF from CONF_ACTIVE or CONF_PASSIVE is the bus-off entry event that sets the bus-off flag. The control register survives a soft reset, and only the hard reset clears it.

Register words are selected by a 2-bit word address:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | listen-only, bus-off interrupt enable, error interrupt enable |
| 1 | status | live status, confinement code, sticky flags |
| 2 | buffer mask | one enable bit per message buffer 32 to 63 |
| 3 | pending | masked buffer completion flags, read-only |

Top module: `can_status_irq`

## Requirements
- R1: After hard reset (rst_n low), every register reads 0, the confinement code reads 00 and irq is 0.
- R2: The status word (address 1) carries the live inputs at the following positions: err_bits at bits 5:0, bus_idle at bit 8 and tx_active at bit 9.
- R3: Status bits 11:10 give the confinement state, one clock after the engine reports it. Engine code 00 reads 00 (error active), code 01 reads 01 (error passive), and codes 10 and 11 read 10 (bus off). The value 11 never appears.
- R4: While listen-only (control bit 0) is 1, the confinement code reads 01 whatever the engine reports. A soft reset does not change the control register, so the code stays 01 across it.
- R5: The bus-off flag (status bit 12) becomes 1 on the clock edge where the state machine enters bus off from error active or error passive.
- R6: The error flag (status bit 13) becomes 1 on any clock edge where at least one of err_bits is 1.
- R7: A write to address 1 with bit 12 or bit 13 set clears the matching flag. Writing 0 to those bits leaves the flag unchanged. If a set event and a clear arrive in the same cycle, the flag stays 1.
- R8: The buffer mask (address 2) holds the enable for buffer 32+i in bit i, so buffer 63 is bit 31. The pending word (address 3) reads buf_done AND mask, bit by bit.
- R9: irq is registered and follows one edge behind its sources. It is the OR of three terms: bus-off flag AND control bit 1, error flag AND control bit 2, and any nonzero pending bit.
- R10: Control bits 31:3 and status bits 7:6 and 31:14 always read 0, and writes to them have no effect.
- R11: A soft reset (soft_rst high at a clock edge) clears both flags and the buffer mask. It sets the confinement state to error active, or to error passive under listen-only, and leaves the control register as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| bus_idle | input | 1 | Engine reports an idle bus |
| tx_active | input | 1 | Engine is transmitting (1) or receiving (0); meaningful only while bus_idle is 0 |
| eng_conf | input | 2 | Engine confinement code: 00 active, 01 passive, 1X bus off |
| err_bits | input | 6 | Individual error event bits |
| buf_done | input | 32 | Completion flags of buffers 32 to 63, buffer 63 in bit 31 |
| irq | output | 1 | Combined interrupt request to the CPU |

## Verification
A wrong confinement state shows up in status bits 11:10 one edge after the engine code changes, and it also shows up as a missing or extra bus-off flag on that same edge. A flag or mask bit that was lost or never cleared is visible at once when address 1 or address 3 is read back. Through irq it appears exactly one edge later, once the matching enable is set. The bench therefore compares the read word and irq against a behavioural model on every clock, so a divergence is reported in the first cycle it becomes visible.

// File: rtl/can_sirq_pkg.sv
package can_sirq_pkg;

    typedef enum logic [1:0] {
        CONF_ACTIVE  = 2'd0,
        CONF_PASSIVE = 2'd1,
        CONF_BUSOFF  = 2'd2
    } conf_e;

    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
    localparam logic [ADDR_W-1:0] A_PEND = 2'd3;

    localparam int CTRL_W      = 3;
    localparam int C_LISTEN    = 0;
    localparam int C_BOFF_EN   = 1;
    localparam int C_ERR_EN    = 2;

    localparam int S_IDLE      = 8;
    localparam int S_TXRX      = 9;
    localparam int S_CONF_LO   = 10;
    localparam int S_CONF_HI   = 11;
    localparam int S_BOFF      = 12;
    localparam int S_ERR       = 13;

endpackage

// File: rtl/can_conf_fsm.sv
module can_conf_fsm
    import can_sirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       listen_only,
    input  logic [1:0] eng_conf,
    output conf_e      state,
    output logic [1:0] conf_code,
    output logic       busoff_entry
);

    conf_e target;
    conf_e nxt;

    always_comb begin
        if (listen_only)
            target = CONF_PASSIVE;
        else if (eng_conf[1])
            target = CONF_BUSOFF;
        else if (eng_conf[0])
            target = CONF_PASSIVE;
        else
            target = CONF_ACTIVE;
    end

    always_comb begin
        nxt          = state;
        busoff_entry = 1'b0;
        if (soft_rst) begin
            nxt = listen_only ? CONF_PASSIVE : CONF_ACTIVE;
        end else begin
            unique case (state)
                CONF_ACTIVE: begin
                    nxt          = target;
                    busoff_entry = (target == CONF_BUSOFF);
                end
                CONF_PASSIVE: begin
                    nxt          = target;
                    busoff_entry = (target == CONF_BUSOFF);
                end
                CONF_BUSOFF: begin
                    nxt = target;
                end
                default: begin
                    nxt = CONF_ACTIVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= CONF_ACTIVE;
        else
            state <= nxt;
    end

    always_comb begin
        unique case (state)
            CONF_ACTIVE:  conf_code = 2'b00;
            CONF_PASSIVE: conf_code = 2'b01;
            CONF_BUSOFF:  conf_code = 2'b10;
            default:      conf_code = 2'b00;
        endcase
    end

endmodule

// File: rtl/can_sirq_ctl_regs.sv
module can_sirq_ctl_regs
    import can_sirq_pkg::*;
#(
    parameter int NUM_BUF = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_ctrl,
    input  logic               wr_mask,
    input  logic [DATA_W-1:0]  wdata,
    output logic [CTRL_W-1:0]  ctrl,
    output logic [NUM_BUF-1:0] mask
);

    // control survives soft reset; only the hard reset clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask <= '0;
        else if (soft_rst)
            mask <= '0;
        else if (wr_mask)
            mask <= wdata[NUM_BUF-1:0];
    end

endmodule

// File: rtl/can_sirq_flags.sv
module can_sirq_flags #(
    parameter int NUM_BUF = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               boff_set,
    input  logic               err_set,
    input  logic               clr_boff,
    input  logic               clr_err,
    input  logic               boff_en,
    input  logic               err_en,
    input  logic [NUM_BUF-1:0] buf_pend,
    output logic               boff_flag,
    output logic               err_flag,
    output logic               irq
);

    // set takes priority over a same-cycle write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boff_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else if (soft_rst) begin
            boff_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            boff_flag <= boff_set | (boff_flag & ~clr_boff);
            err_flag  <= err_set  | (err_flag  & ~clr_err);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= (boff_flag & boff_en) | (err_flag & err_en) | (|buf_pend);
    end

endmodule

// File: rtl/can_status_irq.sv
module can_status_irq
    import can_sirq_pkg::*;
#(
    parameter int NUM_BUF = 32,
    parameter int ERR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                soft_rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                bus_idle,
    input  logic                tx_active,
    input  logic [1:0]          eng_conf,
    input  logic [ERR_W-1:0]    err_bits,
    input  logic [NUM_BUF-1:0]  buf_done,
    output logic                irq
);

    localparam int PAD_W = DATA_W - NUM_BUF;

    conf_e              state;
    logic [1:0]         conf_code;
    logic               busoff_entry;
    logic [CTRL_W-1:0]  ctrl;
    logic [NUM_BUF-1:0] mask;
    logic [NUM_BUF-1:0] buf_pend;
    logic               boff_flag;
    logic               err_flag;
    logic               wr_stat;

    assign wr_stat = wr_en && (addr == A_STAT);

    can_conf_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .listen_only  (ctrl[C_LISTEN]),
        .eng_conf     (eng_conf),
        .state        (state),
        .conf_code    (conf_code),
        .busoff_entry (busoff_entry)
    );

    can_sirq_ctl_regs #(.NUM_BUF(NUM_BUF)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_ctrl  (wr_en && (addr == A_CTRL)),
        .wr_mask  (wr_en && (addr == A_MASK)),
        .wdata    (wdata),
        .ctrl     (ctrl),
        .mask     (mask)
    );

    for (genvar i = 0; i < NUM_BUF; i++) begin : g_pend
        assign buf_pend[i] = buf_done[i] & mask[i];
    end

    can_sirq_flags #(.NUM_BUF(NUM_BUF)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .boff_set  (busoff_entry),
        .err_set   (|err_bits),
        .clr_boff  (wr_stat && wdata[S_BOFF]),
        .clr_err   (wr_stat && wdata[S_ERR]),
        .boff_en   (ctrl[C_BOFF_EN]),
        .err_en    (ctrl[C_ERR_EN]),
        .buf_pend  (buf_pend),
        .boff_flag (boff_flag),
        .err_flag  (err_flag),
        .irq       (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: rdata[CTRL_W-1:0] = ctrl;
            A_STAT: begin
                rdata[ERR_W-1:0]           = err_bits;
                rdata[S_IDLE]              = bus_idle;
                rdata[S_TXRX]              = tx_active;
                rdata[S_CONF_HI:S_CONF_LO] = conf_code;
                rdata[S_BOFF]              = boff_flag;
                rdata[S_ERR]               = err_flag;
            end
            A_MASK: rdata = {{PAD_W{1'b0}}, mask};
            A_PEND: rdata = {{PAD_W{1'b0}}, buf_pend};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/can_status_irq_chk.sv
module can_status_irq_chk
    import can_sirq_pkg::*;
#(
    parameter int ERR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        eng_conf,
    input logic [ERR_W-1:0]  err_bits,
    input logic [1:0]        conf_code,
    input logic [CTRL_W-1:0] ctrl,
    input logic              boff_flag,
    input logic              err_flag,
    input logic              irq
);

    assert_conf_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conf_code != 2'b11);

    assert_listen_passive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[C_LISTEN] |=> conf_code == 2'b01);

    assert_boff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_conf[1] && !ctrl[C_LISTEN] && !soft_rst && conf_code != 2'b10) |=> boff_flag);

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|err_bits) && !soft_rst) |=> err_flag);

    assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT && wdata[S_ERR] && err_bits == '0) |=> !err_flag);

    assert_irq_boff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (boff_flag && ctrl[C_BOFF_EN]) |=> irq);

    assert_ctrl_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> rdata[DATA_W-1:CTRL_W] == '0);

    assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!boff_flag && !err_flag));

endmodule

bind can_status_irq can_status_irq_chk #(.ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .eng_conf  (eng_conf),
    .err_bits  (err_bits),
    .conf_code (conf_code),
    .ctrl      (ctrl),
    .boff_flag (boff_flag),
    .err_flag  (err_flag),
    .irq       (irq)
);

// File: tb/can_status_irq_test.sv
module can_status_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        bus_idle = 1'b0;
    logic        tx_active = 1'b0;
    logic [1:0]  eng_conf = 2'b00;
    logic [5:0]  err_bits = '0;
    logic [31:0] buf_done = '0;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    can_status_irq uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bus_idle(bus_idle),
        .tx_active(tx_active), .eng_conf(eng_conf), .err_bits(err_bits),
        .buf_done(buf_done), .irq(irq)
    );

    // behavioural reference model
    logic [2:0]  m_ctrl;
    logic [31:0] m_mask;
    logic        m_boff, m_err, m_irq;
    int          m_conf;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= '0; m_mask <= '0; m_boff <= 0; m_err <= 0; m_irq <= 0; m_conf <= 0;
        end else begin
            int tgt;
            bit clr_b, clr_e;
            if (m_ctrl[0]) tgt = 1;
            else if (eng_conf[1]) tgt = 2;
            else tgt = int'(eng_conf);
            clr_b = wr_en && addr == 2'd1 && wdata[12];
            clr_e = wr_en && addr == 2'd1 && wdata[13];
            if (wr_en && addr == 2'd0) m_ctrl <= wdata[2:0];
            m_irq <= (m_boff && m_ctrl[1]) || (m_err && m_ctrl[2]) || ((buf_done & m_mask) != 0);
            if (soft_rst) begin
                m_conf <= m_ctrl[0] ? 1 : 0;
                m_boff <= 0; m_err <= 0; m_mask <= '0;
            end else begin
                m_conf <= tgt;
                m_boff <= (tgt == 2 && m_conf != 2) || (m_boff && !clr_b);
                m_err  <= (err_bits != 0) || (m_err && !clr_e);
                if (wr_en && addr == 2'd2) m_mask <= wdata;
            end
        end
    end

    function automatic logic [31:0] model_rd(input logic [1:0] a);
        logic [31:0] r = '0;
        case (a)
            2'd0: r[2:0] = m_ctrl;
            2'd1: begin
                r[5:0] = err_bits; r[8] = bus_idle; r[9] = tx_active;
                r[11:10] = (m_conf == 2) ? 2'b10 : 2'(m_conf);
                r[12] = m_boff; r[13] = m_err;
            end
            2'd2: r = m_mask;
            default: r = buf_done & m_mask;
        endcase
        return r;
    endfunction

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (rdata !== model_rd(addr)) begin
                fails++;
                $display("FAIL %s per-cycle rdata addr=%0d actual=%h expected=%h",
                         addr == 2'd1 ? "R3" : (addr == 2'd0 ? "R10" : "R8"),
                         addr, rdata, model_rd(addr));
            end
            vectors++;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL R9 per-cycle irq actual=%0b expected=%0b", irq, m_irq);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #3;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
        addr = a; #1;
        check(tag, rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(2'd0, "R1 ctrl", 32'h0);
        rd(2'd1, "R1 status", 32'h0);
        rd(2'd2, "R1 mask", 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 live status bits
        bus_idle = 1'b1; err_bits = 6'b000000;
        rd(2'd1, "R2 idle", 32'h0000_0100);
        bus_idle = 1'b0; tx_active = 1'b1;
        rd(2'd1, "R2 tx", 32'h0000_0200);
        tx_active = 1'b0;

        // R3 confinement tracking
        eng_conf = 2'b01; tick();
        rd(2'd1, "R3 passive", 32'h0000_0400);
        // R5 bus-off entry sets the flag, code 11 reads 10
        eng_conf = 2'b11; tick();
        rd(2'd1, "R3/R5 busoff", 32'h0000_1800);
        eng_conf = 2'b00; tick();
        rd(2'd1, "R3 active again", 32'h0000_1000);

        // R7 writing 0 keeps the flag, writing 1 clears it
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, "R7 w0 no effect", 32'h0000_1000);
        wr(2'd1, 32'h0000_1000);
        rd(2'd1, "R7 w1c boff", 32'h0000_0000);

        // R6 error flag, R7 set wins over a clear in the same cycle
        err_bits = 6'b000100;
        addr = 2'd1; wdata = 32'h0000_2000; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wdata = '0;
        rd(2'd1, "R6/R7 set wins", 32'h0000_2004);
        err_bits = '0; tick();
        rd(2'd1, "R6 sticky", 32'h0000_2000);

        // R9 irq gated by enable, one edge behind
        check("R9 masked off", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h0000_0004);
        check("R9 not yet", {31'd0, irq}, 32'd0);
        tick();
        check("R9 err irq", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h0000_2000);
        tick();
        check("R9 irq drops", {31'd0, irq}, 32'd0);

        // R8 buffer masking, buffer 63 at bit 31
        buf_done = 32'h8000_0001;
        rd(2'd3, "R8 unmasked", 32'h0);
        wr(2'd2, 32'h8000_0000);
        rd(2'd3, "R8 pending", 32'h8000_0000);
        tick();
        check("R8/R9 buf irq", {31'd0, irq}, 32'd1);

        // R10 reserved bits
        wr(2'd0, 32'hFFFF_FFF8);
        rd(2'd0, "R10 ctrl reserved", 32'h0);
        bus_idle = 1'b0; wr(2'd1, 32'hFFFF_C0C0);
        rd(2'd1, "R10 status reserved", 32'h0);

        // R4 listen-only forces passive, no bus-off entry
        wr(2'd0, 32'h0000_0001);
        eng_conf = 2'b10; tick(); tick();
        rd(2'd1, "R4 listen passive", 32'h0000_0400);

        // R11 soft reset: mask cleared, ctrl kept, code stays passive
        err_bits = 6'b000001; tick(); err_bits = '0;
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        rd(2'd1, "R4/R11 soft keeps passive", 32'h0000_0400);
        rd(2'd0, "R11 ctrl kept", 32'h0000_0001);
        rd(2'd2, "R11 mask cleared", 32'h0);

        // R11 soft reset out of listen-only lands in error active
        wr(2'd0, 32'h0); eng_conf = 2'b01; tick();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        rd(2'd1, "R11 soft active", 32'h0000_0000);
        tick();
        rd(2'd1, "R3 resumes", 32'h0000_0400);

        eng_conf = 2'b00; buf_done = '0;
        repeat (3) tick();
        done = 1'b1;
        summary();
    end

endmodule